// File: doc/BRIEF.md
# Standby Wakeup and Bus-Release Controller

This block puts a small 8-bit processor into a deep low-power standby state and brings it back out. Standby is armed by a sleep strobe from the core, and only when a two-bit mode field in the CPU control register holds the pattern high/low and the I/O stop bit is set. In standby the block turns off both the oscillator enable and the internal clock enable, and it holds the address and bus-control pins driven high.

A wake request is either an interrupt request or, when the bus-exit enable bit is set, a bus request. Both are passed through two-flop synchronizers into the restarted oscillator clock. On a wake request the oscillator enable comes back at once, and a settling counter then runs for `SETTLE_CYCLES` cycles. The default is 2^17, held in an 18-bit counter. The request that caused the wake must stay asserted for the whole count. If it drops, the block falls back into standby. When the count completes, the clocks resume. An interrupt wake then gets a one-cycle acknowledge and returns to run. A bus wake floats the address and bus-control pins and raises bus acknowledge until the bus request is released.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After reset, oscEn=1, clkEn=1, addrOe=1, ctlOe=1, busAck=0 and irqAck=0, and addrOut/ctlOut follow addrIn/ctlIn.
- R2: A one-cycle sleepStrobe stops both enables after that clock edge only if modeBitHi=1, modeBitLo=0 and ioStopBit=1. Any other combination leaves oscEn and clkEn at 1.
- R3: In standby, oscEn=0 and clkEn=0, and addrOut and ctlOut are driven all ones with addrOe=ctlOe=1.
- R4: A wake request passes through two synchronizer flops. oscEn rises after the third rising clock edge from the request being asserted, and not before.
- R5: After oscEn rises, clkEn stays 0 for exactly SETTLE_CYCLES cycles. clkEn is never 1 while oscEn is 0. The counter is wide enough for the default of 2^17.
- R6: If the waking request drops during the settling count, oscEn returns to 0 after the third clock edge from the drop, and clkEn does not rise.
- R7: An interrupt wake raises clkEn and irqAck together. irqAck lasts exactly one cycle, and the block then runs with the bus driven from the core.
- R8: A bus wake with busExitEn=1 raises clkEn and busAck together, with addrOe=0 and ctlOe=0 for as long as busAck is high.
- R9: Once busReq is released, busAck falls, and addrOe/ctlOe return to 1, after the third clock edge from the release.
- R10: With busExitEn=0, a bus request in standby is ignored: oscEn stays 0 and busAck stays 0.
- R11: When interrupt and bus requests arrive in the same cycle with busExitEn=1, the interrupt wins: irqAck pulses and busAck stays 0.
- R12: While running, irqReq and busReq have no effect: oscEn=1, clkEn=1 and busAck=0 stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Restarted oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sleepStrobe | input | 1 | One-cycle sleep instruction strobe from the core |
| modeBitHi | input | 1 | Mode field bit that must be 1 to arm standby |
| modeBitLo | input | 1 | Mode field bit that must be 0 to arm standby |
| ioStopBit | input | 1 | I/O stop control bit |
| busExitEn | input | 1 | Allows a bus request to end standby |
| irqReq | input | 1 | External interrupt request (asynchronous) |
| busReq | input | 1 | External bus request (asynchronous) |
| addrIn | input | 20 | Address from the core |
| ctlIn | input | 4 | Memory-request, I/O-request, read and write from the core |
| oscEn | output | 1 | Oscillator enable |
| clkEn | output | 1 | Internal clock enable |
| addrOut | output | 20 | Address pin value |
| addrOe | output | 1 | Address pin output enable |
| ctlOut | output | 4 | Bus-control pin values |
| ctlOe | output | 1 | Bus-control pin output enable |
| busAck | output | 1 | Bus acknowledge |
| irqAck | output | 1 | Interrupt wake acknowledge, one cycle |

## Verification
A sleep strobe takes effect on the enables one clock edge after it is sampled. A change on irqReq or busReq reaches the outputs three edges later: two synchronizer stages plus the state register. The resumed clocks and the acknowledges follow SETTLE_CYCLES edges after oscEn rises. The bench drives inputs and samples outputs on falling edges. It steps an exact number of edges derived from these delays. It checks one edge before each change that the old value still holds, and checks the new value on the edge where it is due. With the settling count shortened to 16, random arming patterns and random abort points inside the count are checked against bench functions built from the requirements.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    ST_RUN         = 3'd0,
    ST_STANDBY     = 3'd1,
    ST_SETTLE      = 3'd2,
    ST_BUS_GRANTED = 3'd3,
    ST_INT_ACK     = 3'd4
  } stbyState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntLoad;    // load settling counter
    logic cntDec;     // decrement settling counter
    logic driveCore;  // pins follow core values
    logic releaseBus; // pins floated
  } dpCtl_t;

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[gi] <= '0;
          else       stageQ[gi] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[gi] <= '0;
          else       stageQ[gi] <= stageQ[gi-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sleepStrobe,
  input  logic   modeBitHi,
  input  logic   modeBitLo,
  input  logic   ioStopBit,
  input  logic   busExitEn,
  input  logic   irqSync,
  input  logic   busSync,
  input  logic   cntZero,
  output dpCtl_t dpCtl,
  output logic   oscEn,
  output logic   clkEn,
  output logic   busAck,
  output logic   irqAck
);

  stbyState_t stateQ, stateD;
  logic       srcBusQ, srcBusD;
  logic       armOk;
  logic       srcHeld;

  assign armOk   = sleepStrobe && modeBitHi && !modeBitLo && ioStopBit;
  assign srcHeld = srcBusQ ? busSync : irqSync;

  always_comb begin
    stateD  = stateQ;
    srcBusD = srcBusQ;
    case (stateQ)
      ST_RUN: begin
        if (armOk) stateD = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (irqSync) begin
          stateD  = ST_SETTLE;
          srcBusD = 1'b0;
        end else if (busSync && busExitEn) begin
          stateD  = ST_SETTLE;
          srcBusD = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (!srcHeld)     stateD = ST_STANDBY;
        else if (cntZero) stateD = srcBusQ ? ST_BUS_GRANTED : ST_INT_ACK;
      end
      ST_INT_ACK: begin
        stateD = ST_RUN;
      end
      ST_BUS_GRANTED: begin
        if (!busSync) stateD = ST_RUN;
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_RUN;
      srcBusQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      srcBusQ <= srcBusD;
    end
  end

  always_comb begin
    dpCtl.cntLoad    = (stateQ == ST_STANDBY) && (stateD == ST_SETTLE);
    dpCtl.cntDec     = (stateQ == ST_SETTLE) && !cntZero;
    dpCtl.driveCore  = (stateQ == ST_RUN);
    dpCtl.releaseBus = (stateQ == ST_BUS_GRANTED);
  end

  assign oscEn  = (stateQ != ST_STANDBY);
  assign clkEn  = (stateQ == ST_RUN) || (stateQ == ST_INT_ACK) ||
                  (stateQ == ST_BUS_GRANTED);
  assign busAck = (stateQ == ST_BUS_GRANTED);
  assign irqAck = (stateQ == ST_INT_ACK);

endmodule

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1 << 17,
  parameter int ADDR_W        = 20,
  parameter int CTL_W         = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [CTL_W-1:0]  ctlIn,
  output logic              cntZero,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [CTL_W-1:0]  ctlOut,
  output logic              ctlOe
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntQ <= '0;
    else if (dpCtl.cntLoad) cntQ <= CNT_LOAD;
    else if (dpCtl.cntDec)  cntQ <= cntQ - 1'b1;
  end

  assign cntZero = (cntQ == '0);

  // pins: core values in run, idle high otherwise, floated when granted
  assign addrOut = dpCtl.driveCore ? addrIn : '1;
  assign ctlOut  = dpCtl.driveCore ? ctlIn  : '1;
  assign addrOe  = !dpCtl.releaseBus;
  assign ctlOe   = !dpCtl.releaseBus;

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1 << 17,
  parameter int ADDR_W        = 20,
  parameter int CTL_W         = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepStrobe,
  input  logic              modeBitHi,
  input  logic              modeBitLo,
  input  logic              ioStopBit,
  input  logic              busExitEn,
  input  logic              irqReq,
  input  logic              busReq,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [CTL_W-1:0]  ctlIn,
  output logic              oscEn,
  output logic              clkEn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [CTL_W-1:0]  ctlOut,
  output logic              ctlOe,
  output logic              busAck,
  output logic              irqAck
);

  logic [1:0] reqSync;
  dpCtl_t     dpCtl;
  logic       cntZero;

  stby_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({busReq, irqReq}),
    .syncOut (reqSync)
  );

  stby_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .sleepStrobe (sleepStrobe),
    .modeBitHi   (modeBitHi),
    .modeBitLo   (modeBitLo),
    .ioStopBit   (ioStopBit),
    .busExitEn   (busExitEn),
    .irqSync     (reqSync[0]),
    .busSync     (reqSync[1]),
    .cntZero     (cntZero),
    .dpCtl       (dpCtl),
    .oscEn       (oscEn),
    .clkEn       (clkEn),
    .busAck      (busAck),
    .irqAck      (irqAck)
  );

  stby_datapath #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .ADDR_W        (ADDR_W),
    .CTL_W         (CTL_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .addrIn  (addrIn),
    .ctlIn   (ctlIn),
    .cntZero (cntZero),
    .addrOut (addrOut),
    .addrOe  (addrOe),
    .ctlOut  (ctlOut),
    .ctlOe   (ctlOe)
  );

endmodule

// File: rtl/stby_wake_checker.sv
module stby_wake_checker (
  input logic clk,
  input logic rstN,
  input logic oscEn,
  input logic clkEn,
  input logic addrOe,
  input logic ctlOe,
  input logic busAck,
  input logic irqAck,
  input logic busReq
);

  assert_clk_needs_osc_R5: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> oscEn);

  assert_grant_floats_bus_R8: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> (!addrOe && !ctlOe));

  assert_ack_single_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !irqAck);

  assert_ack_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(irqAck && busAck));

  assert_release_on_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && !$past(busReq, 2)) |=> (!busAck && addrOe && ctlOe));

  assert_ack_with_clock_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck || busAck) |-> clkEn);

endmodule

bind stby_wake_ctrl stby_wake_checker chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .oscEn  (oscEn),
  .clkEn  (clkEn),
  .addrOe (addrOe),
  .ctlOe  (ctlOe),
  .busAck (busAck),
  .irqAck (irqAck),
  .busReq (busReq)
);

// File: tb/stby_wake_ctrl_tb.sv
module stby_wake_ctrl_tb_top;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sleepStrobe = 1'b0;
  logic        modeBitHi = 1'b0;
  logic        modeBitLo = 1'b0;
  logic        ioStopBit = 1'b0;
  logic        busExitEn = 1'b0;
  logic        irqReq = 1'b0;
  logic        busReq = 1'b0;
  logic [19:0] addrIn = 20'h12345;
  logic [3:0]  ctlIn = 4'h5;
  logic        oscEn, clkEn, addrOe, ctlOe, busAck, irqAck;
  logic [19:0] addrOut;
  logic [3:0]  ctlOut;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  stby_wake_ctrl #(.SETTLE_CYCLES(N)) dut_i (
    .clk(clk), .rstN(rstN), .sleepStrobe(sleepStrobe), .modeBitHi(modeBitHi),
    .modeBitLo(modeBitLo), .ioStopBit(ioStopBit), .busExitEn(busExitEn),
    .irqReq(irqReq), .busReq(busReq), .addrIn(addrIn), .ctlIn(ctlIn),
    .oscEn(oscEn), .clkEn(clkEn), .addrOut(addrOut), .addrOe(addrOe),
    .ctlOut(ctlOut), .ctlOe(ctlOe), .busAck(busAck), .irqAck(irqAck)
  );

  function automatic logic expArm(logic hi, logic lo, logic io);
    return hi && !lo && io;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sleepPulse(logic hi, logic lo, logic io);
    modeBitHi = hi; modeBitLo = lo; ioStopBit = io;
    sleepStrobe = 1'b1;
    step(1);
    sleepStrobe = 1'b0;
  endtask

  task automatic enterStandby();
    sleepPulse(1'b1, 1'b0, 1'b1);
    check("R2 enter oscEn", 32'(oscEn), 0);
    check("R3 standby clkEn", 32'(clkEn), 0);
    check("R3 idle addr high", 32'(addrOut), 32'hFFFFF);
    check("R3 idle ctl high", 32'({ctlOe, ctlOut}), 32'h1F);
  endtask

  task automatic irqWake();
    irqReq = 1'b1;
    step(2);
    check("R4 osc still off", 32'(oscEn), 0);
    step(1);
    check("R4 osc on", 32'(oscEn), 1);
    check("R5 clk off at settle start", 32'(clkEn), 0);
    step(N - 1);
    check("R5 clk off at settle end", 32'(clkEn), 0);
    step(1);
    check("R7 clk resumes", 32'(clkEn), 1);
    check("R7 irqAck", 32'(irqAck), 1);
    check("R11 no busAck", 32'(busAck), 0);
    irqReq = 1'b0;
    busReq = 1'b0;
    step(1);
    check("R7 irqAck one cycle", 32'(irqAck), 0);
    check("R7 run drives core", 32'({addrOe, addrOut}), 32'({1'b1, addrIn}));
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    check("R1 oscEn", 32'(oscEn), 1);
    check("R1 clkEn", 32'(clkEn), 1);
    check("R1 oe", 32'({addrOe, ctlOe}), 3);
    check("R1 acks", 32'({busAck, irqAck}), 0);
    check("R1 addr passthrough", 32'(addrOut), 32'(addrIn));
    check("R1 ctl passthrough", 32'(ctlOut), 32'(ctlIn));

    // R12: requests while running have no effect
    irqReq = 1'b1; busReq = 1'b1; busExitEn = 1'b1;
    step(10);
    check("R12 clkEn", 32'(clkEn), 1);
    check("R12 oscEn", 32'(oscEn), 1);
    check("R12 busAck", 32'(busAck), 0);
    irqReq = 1'b0; busReq = 1'b0; busExitEn = 1'b0;
    step(3);

    // R2: random arming patterns
    void'($urandom(32'd1234));
    for (int i = 0; i < 24; i++) begin
      logic hi, lo, io, arm;
      hi = 1'($urandom); lo = 1'($urandom); io = 1'($urandom);
      arm = expArm(hi, lo, io);
      sleepPulse(hi, lo, io);
      check("R2 arming", 32'({oscEn, clkEn}), arm ? 0 : 3);
      if (arm) irqWake();
    end

    // R6: random abort points inside the count
    for (int i = 0; i < 5; i++) begin
      int d;
      d = 1 + int'($urandom_range(N - 4));
      enterStandby();
      irqReq = 1'b1;
      step(3 + d);
      irqReq = 1'b0;
      step(2);
      check("R6 osc on before abort", 32'(oscEn), 1);
      step(1);
      check("R6 abort osc off", 32'(oscEn), 0);
      step(N + 4);
      check("R6 no resume", 32'({oscEn, clkEn, irqAck}), 0);
      irqWake();
    end

    // R10: bus request ignored when exit disabled
    enterStandby();
    busExitEn = 1'b0;
    busReq = 1'b1;
    step(N + 8);
    check("R10 osc stays off", 32'(oscEn), 0);
    check("R10 no busAck", 32'(busAck), 0);
    busReq = 1'b0;
    step(3);
    irqWake();

    // R8 / R9: bus exit and release
    enterStandby();
    busExitEn = 1'b1;
    busReq = 1'b1;
    step(3 + N - 1);
    check("R8 clk off during settle", 32'({oscEn, clkEn}), 2);
    step(1);
    check("R8 clk resumes", 32'(clkEn), 1);
    check("R8 busAck", 32'(busAck), 1);
    check("R8 pins floated", 32'({addrOe, ctlOe}), 0);
    step(5);
    check("R8 grant held", 32'({busAck, addrOe}), 2);
    busReq = 1'b0;
    step(2);
    check("R9 busAck held two edges", 32'(busAck), 1);
    step(1);
    check("R9 busAck released", 32'(busAck), 0);
    check("R9 pins driven", 32'({addrOe, ctlOe}), 3);
    check("R9 running", 32'(clkEn), 1);

    // R11: simultaneous requests, interrupt wins
    enterStandby();
    busExitEn = 1'b1;
    busReq = 1'b1;
    irqWake();
    step(3);
    check("R11 no late busAck", 32'(busAck), 0);
    check("R11 running", 32'(clkEn), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule